// File: doc/BRIEF.md
# Instruction Fetch Byte Buffer

This block sits between an instruction cache and the instruction decoders. It holds a sixteen-byte window of the instruction stream and shows it to the decoders every cycle. The first valid byte is always on the lowest byte lane, and a count says how many lanes hold valid bytes. Each cycle the decoders say how many bytes they took, anywhere from zero to the full window. Storage is kept as memory-aligned two-byte words. A word is released only after both of its bytes have been taken, and released words are refilled from the cache in the same word units.

The cache is modelled as a read port that takes a sixteen-byte-aligned address and returns the thirty-two bytes that start there, one cycle later. A refill starts at any even address, so its sixteen bytes fit in that window even when they cross a thirty-two-byte line boundary. A line-crossing refill therefore costs no extra cycle. A redirect (a control transfer) empties the buffer, drops any cache data already on its way, and fetches sixteen bytes starting at the target. The cache returns bytes only from even addresses, so an odd target marks the first byte of the first word as already taken.

A small state machine controls fetching. HALT is the state after reset, with no fetch stream yet. RELOAD means the fetch for a redirect target is outstanding. STREAM is normal refilling. The transitions are HALT to RELOAD on a redirect, RELOAD to STREAM when the target data arrives, and STREAM to RELOAD on a redirect. A redirect while in RELOAD restarts RELOAD.

Top module: `ifetch_bytebuf`

## Requirements
- R1: After reset `avail_o` is 0, `ic_req_o` is low, and `overrun_o` is low while `take_i` is 0.
- R2: In the cycle of a redirect, `ic_req_o` is high and `ic_addr_o` is the target with its low four bits cleared. Two cycles later, with no second redirect, the window holds the bytes starting at the target. Byte i of the window sits at `win_o[8i+7:8i]`.
- R3: For an odd target, the byte at the even address below the target is never shown. The window holds 15 bytes starting at the target.
- R4: Taking n bytes, with n no larger than `avail_o`, moves the head by n. In the next cycle, lane 0 holds the byte at the old head address plus n.
- R5: Each non-redirect cycle after the first redirect, the buffer computes `free = 8 - (words kept after this cycle's take) - (words in flight)`. If `free` is non-zero, it requests that many words, starting at the word after the last one requested. A word is kept while either of its bytes is untaken. The data is appended at the end of the next cycle.
- R6: Every request address is sixteen-byte aligned. The cache returns byte j of the 32-byte window at `ic_data_i[8j+7:8j]`. A refill that crosses a 32-byte line boundary completes in that single return.
- R7: A redirect discards all resident bytes and any cache data returning in the same cycle, and ignores `take_i` in that cycle. `avail_o` is 0 in the next cycle.
- R8: If `take_i` is greater than `avail_o`, only `avail_o` bytes are taken, and `overrun_o` is high in that same cycle unless a redirect is present.
- R9: No cache request is made before the first redirect after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redir_i | input | 1 | Control transfer: flush and refetch |
| redir_pc_i | input | ADDR_W | Byte address of the transfer target |
| take_i | input | CW | Bytes taken by the decoders this cycle |
| win_o | output | 8*BUF_BYTES | Byte window; lane 0 is the oldest byte |
| avail_o | output | CW | Count of valid lanes in `win_o` |
| overrun_o | output | 1 | `take_i` exceeded the valid byte count |
| ic_req_o | output | 1 | Cache read request |
| ic_addr_o | output | ADDR_W | Sixteen-byte-aligned cache read address |
| ic_data_i | input | 16*BUF_BYTES | Cache bytes, returned one cycle after the request |

## Verification
A wrong head position or odd-byte flag shows up at once as wrong bytes on lane 0 of `win_o`. A wrong word count shows up in the same cycle as a wrong `avail_o`. Because the refill size depends on that count, a wrong count also changes the next cycle's `ic_req_o` and `ic_addr_o`. A missing drop of returning data after a redirect leaves `avail_o` non-zero in the cycle after the redirect, and a misplaced append shows up in the window two cycles after the request.

// File: rtl/ifb_pkg.sv
`timescale 1ns/1ps
package ifb_pkg;
    // Fetch control states
    typedef enum logic [1:0] {
        FS_HALT   = 2'd0,   // no fetch stream since reset
        FS_RELOAD = 2'd1,   // target fetch outstanding
        FS_STREAM = 2'd2    // normal word refill
    } ifb_state_e;
endpackage

// File: rtl/ifb_ctrl.sv
`timescale 1ns/1ps
module ifb_ctrl
    import ifb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NW     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      redir_i,
    input  logic [ADDR_W-1:0]         redir_pc_i,
    input  logic [$clog2(NW)+1:0]     take_i,
    output logic [$clog2(NW)+1:0]     avail_o,
    output logic                      overrun_o,
    output logic                      ic_req_o,
    output logic [ADDR_W-1:0]         ic_addr_o,
    output logic                      ap_en_o,
    output logic [$clog2(NW)-1:0]     ap_slot_o,
    output logic [$clog2(NW):0]       ap_cnt_o,
    output logic [$clog2(NW):0]       ap_off_o,
    output logic [$clog2(NW):0]       head_byte_o
);
    localparam int PW = $clog2(NW);
    localparam int OW = PW + 1;
    localparam int CW = PW + 2;
    localparam logic [PW:0] NW_C = (PW+1)'(NW);

    ifb_state_e st_q, st_d;

    logic [PW-1:0]     hw_q;
    logic              hodd_q;
    logic [PW:0]       wcnt_q;
    logic [ADDR_W-1:0] tail_q;
    logic              infl_q;
    logic [PW:0]       icnt_q;
    logic [OW-1:0]     ioff_q;

    logic [CW-1:0]     avail, n_take, sum;
    logic              over, arrive;
    logic [PW:0]       freed, keep, inflw, room;

    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_ptr;
    logic [PW:0]       fetch_cnt;

    // occupancy and consume arithmetic
    always_comb begin
        avail  = (wcnt_q == '0) ? '0 : ({wcnt_q, 1'b0} - {{(CW-1){1'b0}}, hodd_q});
        over   = (take_i > avail);
        n_take = over ? avail : take_i;
        sum    = n_take + {{(CW-1){1'b0}}, hodd_q};
        freed  = sum[CW-1:1];
        keep   = wcnt_q - freed;
        inflw  = infl_q ? icnt_q : '0;
        room   = NW_C - keep - inflw;
        arrive = infl_q & ~redir_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_HALT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_HALT:   if (redir_i) st_d = FS_RELOAD;
            FS_RELOAD: begin
                if (redir_i)     st_d = FS_RELOAD;
                else if (arrive) st_d = FS_STREAM;
            end
            FS_STREAM: if (redir_i) st_d = FS_RELOAD;
            default:   st_d = FS_HALT;
        endcase
    end

    // state outputs: fetch request
    always_comb begin
        fetch_go  = 1'b0;
        fetch_ptr = tail_q;
        fetch_cnt = room;
        if (redir_i) begin
            fetch_go  = 1'b1;
            fetch_ptr = {redir_pc_i[ADDR_W-1:1], 1'b0};
            fetch_cnt = NW_C;
        end else begin
            unique case (st_q)
                FS_HALT:              fetch_go = 1'b0;
                FS_RELOAD, FS_STREAM: fetch_go = (room != '0);
                default:              fetch_go = 1'b0;
            endcase
        end
    end

    // queue bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_q   <= '0;
            hodd_q <= 1'b0;
            wcnt_q <= '0;
            tail_q <= '0;
            infl_q <= 1'b0;
            icnt_q <= '0;
            ioff_q <= '0;
        end else if (redir_i) begin
            hw_q   <= '0;
            wcnt_q <= '0;
            hodd_q <= redir_pc_i[0];
            tail_q <= {redir_pc_i[ADDR_W-1:1], 1'b0} + ADDR_W'(2*NW);
            infl_q <= 1'b1;
            icnt_q <= NW_C;
            ioff_q <= {redir_pc_i[OW-1:1], 1'b0};
        end else begin
            hw_q   <= hw_q + freed[PW-1:0];
            wcnt_q <= keep + (arrive ? icnt_q : '0);
            hodd_q <= sum[0];
            infl_q <= fetch_go;
            icnt_q <= fetch_cnt;
            ioff_q <= fetch_ptr[OW-1:0];
            if (fetch_go) tail_q <= tail_q + ADDR_W'({fetch_cnt, 1'b0});
        end
    end

    assign avail_o     = avail;
    assign overrun_o   = over & ~redir_i;
    assign ic_req_o    = fetch_go;
    assign ic_addr_o   = {fetch_ptr[ADDR_W-1:OW], {OW{1'b0}}};
    assign ap_en_o     = arrive;
    assign ap_slot_o   = hw_q + wcnt_q[PW-1:0];
    assign ap_cnt_o    = icnt_q;
    assign ap_off_o    = ioff_q;
    assign head_byte_o = {hw_q, hodd_q};
endmodule

// File: rtl/ifb_store.sv
`timescale 1ns/1ps
module ifb_store #(
    parameter int NW        = 8,
    parameter int WIN_BYTES = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ap_en_i,
    input  logic [$clog2(NW)-1:0]     ap_slot_i,
    input  logic [$clog2(NW):0]       ap_cnt_i,
    input  logic [$clog2(NW):0]       ap_off_i,
    input  logic [8*WIN_BYTES-1:0]    ic_data_i,
    input  logic [$clog2(NW):0]       head_byte_i,
    output logic [16*NW-1:0]          win_o
);
    localparam int PW = $clog2(NW);
    localparam int SW = $clog2(WIN_BYTES);

    logic [16*NW-1:0] flat;

    // one word register per slot, written from the returned window
    for (genvar s = 0; s < NW; s++) begin : g_slot
        logic [PW-1:0] rel;
        logic [SW-1:0] pos;
        logic          hit;
        logic [15:0]   w_q;

        assign rel = PW'(s) - ap_slot_i;
        assign hit = ap_en_i && ({1'b0, rel} < ap_cnt_i);
        assign pos = SW'(ap_off_i) + SW'({rel, 1'b0});

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   w_q <= '0;
            else if (hit) w_q <= ic_data_i[pos*8 +: 16];
        end

        assign flat[s*16 +: 16] = w_q;
    end

    // rotate so that the head byte lands on lane 0
    for (genvar b = 0; b < 2*NW; b++) begin : g_lane
        logic [PW:0] idx;
        assign idx = head_byte_i + (PW+1)'(b);
        assign win_o[b*8 +: 8] = flat[idx*8 +: 8];
    end
endmodule

// File: rtl/ifetch_bytebuf.sv
`timescale 1ns/1ps
module ifetch_bytebuf #(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           redir_i,
    input  logic [ADDR_W-1:0]              redir_pc_i,
    input  logic [$clog2(BUF_BYTES/2)+1:0] take_i,
    output logic [8*BUF_BYTES-1:0]         win_o,
    output logic [$clog2(BUF_BYTES/2)+1:0] avail_o,
    output logic                           overrun_o,
    output logic                           ic_req_o,
    output logic [ADDR_W-1:0]              ic_addr_o,
    input  logic [16*BUF_BYTES-1:0]        ic_data_i
);
    localparam int NW  = BUF_BYTES / 2;
    localparam int PW  = $clog2(NW);
    localparam int WIN = 2 * BUF_BYTES;

    logic          ap_en;
    logic [PW-1:0] ap_slot;
    logic [PW:0]   ap_cnt, ap_off, head_byte;

    ifb_ctrl #(.ADDR_W(ADDR_W), .NW(NW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_i     (redir_i),
        .redir_pc_i  (redir_pc_i),
        .take_i      (take_i),
        .avail_o     (avail_o),
        .overrun_o   (overrun_o),
        .ic_req_o    (ic_req_o),
        .ic_addr_o   (ic_addr_o),
        .ap_en_o     (ap_en),
        .ap_slot_o   (ap_slot),
        .ap_cnt_o    (ap_cnt),
        .ap_off_o    (ap_off),
        .head_byte_o (head_byte)
    );

    ifb_store #(.NW(NW), .WIN_BYTES(WIN)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .ap_en_i     (ap_en),
        .ap_slot_i   (ap_slot),
        .ap_cnt_i    (ap_cnt),
        .ap_off_i    (ap_off),
        .ic_data_i   (ic_data_i),
        .head_byte_i (head_byte),
        .win_o       (win_o)
    );
endmodule

// File: rtl/ifb_checker.sv
`timescale 1ns/1ps
module ifb_checker #(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           redir_i,
    input logic [ADDR_W-1:0]              redir_pc_i,
    input logic [$clog2(BUF_BYTES/2)+1:0] take_i,
    input logic [$clog2(BUF_BYTES/2)+1:0] avail_o,
    input logic                           overrun_o,
    input logic                           ic_req_o,
    input logic [ADDR_W-1:0]              ic_addr_o
);
    localparam int OW = $clog2(BUF_BYTES);

    logic seen_redir;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_redir <= 1'b0;
        else if (redir_i) seen_redir <= 1'b1;
    end

    // R9
    a_r9_quiet_before_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_redir && !redir_i) |-> !ic_req_o);

    // R2
    a_r2_redirect_request: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i |-> (ic_req_o && ic_addr_o[ADDR_W-1:OW] == redir_pc_i[ADDR_W-1:OW]
                     && ic_addr_o[OW-1:0] == '0));

    // R7
    a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i |=> (avail_o == '0));

    // R3
    a_r3_odd_target: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_i && redir_pc_i[0]) ##1 !redir_i |=> (avail_o == BUF_BYTES - 1));

    // R8
    a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> (take_i > avail_o && !redir_i));

    // R4
    a_r4_avail_bound: assert property (@(posedge clk) disable iff (!rst_n)
        avail_o <= BUF_BYTES);
endmodule

bind ifetch_bytebuf ifb_checker #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_i    (redir_i),
    .redir_pc_i (redir_pc_i),
    .take_i     (take_i),
    .avail_o    (avail_o),
    .overrun_o  (overrun_o),
    .ic_req_o   (ic_req_o),
    .ic_addr_o  (ic_addr_o)
);

// File: tb/ifetch_bytebuf_tb.sv
`timescale 1ns/1ps
module ifetch_bytebuf_tb;
    localparam int AW  = 32;
    localparam int BB  = 16;
    localparam int NW  = 8;
    localparam int CW  = 5;
    localparam int WIN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            redir = 1'b0;
    logic [AW-1:0]   redir_pc = '0;
    logic [CW-1:0]   take = '0;
    logic [8*BB-1:0] win;
    logic [CW-1:0]   avail;
    logic            overrun, ic_req;
    logic [AW-1:0]   ic_addr;
    logic [8*WIN-1:0] ic_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int          m_wc = 0, m_odd = 0, m_icnt = 0;
    int unsigned m_head = 0, m_tail = 0;
    bit          m_infl = 1'b0, m_run = 1'b0;

    always #2.5 clk = ~clk;

    ifetch_bytebuf #(.ADDR_W(AW), .BUF_BYTES(BB)) u_dut (
        .clk(clk), .rst_n(rst_n), .redir_i(redir), .redir_pc_i(redir_pc),
        .take_i(take), .win_o(win), .avail_o(avail), .overrun_o(overrun),
        .ic_req_o(ic_req), .ic_addr_o(ic_addr), .ic_data_i(ic_data)
    );

    function automatic logic [7:0] memb(input int unsigned a);
        return 8'((a * 37) ^ (a >> 7));
    endfunction

    // cache model: window of 32 bytes from the requested base, one cycle later
    always @(posedge clk)
        if (ic_req)
            for (int j = 0; j < WIN; j++) ic_data[8*j +: 8] <= memb(ic_addr + j);

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit rd, input int unsigned pc, input int tk, input string tag);
        int ea, n, freed, keep, room, bad;
        bit eo, er;
        int unsigned eaddr;
        @(negedge clk);
        redir = rd; redir_pc = pc; take = CW'(tk);
        #1;
        ea = (m_wc == 0) ? 0 : 2*m_wc - m_odd;
        chk(tag, "avail", avail, ea);
        bad = 0;
        for (int b = 0; b < ea; b++)
            if (win[8*b +: 8] != memb(m_head + b)) bad++;
        chk(tag, "mismatching window bytes", bad, 0);
        eo = !rd && (tk > ea);
        chk(tag, "overrun", overrun, eo);
        eaddr = 0;
        if (rd) begin
            er = 1'b1; eaddr = pc & ~32'hF;
            m_wc = 0; m_odd = pc & 1; m_head = pc;
            m_infl = 1'b1; m_icnt = NW; m_tail = (pc & ~32'h1) + 2*NW; m_run = 1'b1;
        end else begin
            n = (tk > ea) ? ea : tk;
            freed = (m_odd + n) / 2;
            m_odd = (m_odd + n) % 2;
            m_head += n;
            keep = m_wc - freed;
            room = NW - keep - (m_infl ? m_icnt : 0);
            er = m_run && room > 0;
            eaddr = m_tail & ~32'hF;
            m_wc = keep + (m_infl ? m_icnt : 0);
            m_infl = er;
            m_icnt = room;
            if (er) m_tail += 2*room;
        end
        chk(tag, "request", ic_req, er);
        if (er) chk(tag, "request address", ic_addr, eaddr);
    endtask

    initial begin
        int seq[14] = '{1, 1, 1, 3, 2, 5, 7, 16, 4, 9, 0, 11, 16, 16};
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state, R9 no fetch before redirect, R8 overrun while empty
        step(0, 0, 0, "R1");
        step(0, 0, 0, "R1");
        step(0, 0, 3, "R8");
        step(0, 0, 0, "R9");
        // R2 even target, R7 empty after redirect
        step(1, 32'h1000, 0, "R2");
        step(0, 0, 0, "R7");
        step(0, 0, 0, "R2");
        // R4 / R5 byte-granular take, word release and refill
        for (int i = 0; i < 14; i++) step(0, 0, seq[i], (i < 7) ? "R4" : "R5");
        // R3 odd target
        step(1, 32'h2017, 0, "R3");
        step(0, 0, 0, "R3");
        step(0, 0, 1, "R3");
        step(0, 0, 2, "R5");
        step(0, 0, 0, "R5");
        // R6 refill across a 32-byte line boundary
        step(1, 32'h201D, 0, "R6");
        step(0, 0, 0, "R6");
        step(0, 0, 4, "R6");
        step(0, 0, 6, "R6");
        step(0, 0, 8, "R6");
        step(0, 0, 0, "R6");
        // R7 redirect while refill data is returning; take ignored
        step(0, 0, 16, "R7");
        step(1, 32'h3005, 4, "R7");
        step(0, 0, 2, "R7");
        step(0, 0, 0, "R7");
        step(0, 0, 3, "R7");
        // R8 clamp
        step(0, 0, 31, "R8");
        step(0, 0, 0, "R8");
        step(0, 0, 20, "R8");
        // back-to-back redirects
        step(1, 32'h4000, 0, "R7");
        step(1, 32'h4101, 0, "R3");
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R3");
        // long mixed run
        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 49) step(1, 32'h5000 + i*13, 3, "R7");
            else              step(0, 0, (i*7) % 19, "R5");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule